// File: doc/BRIEF.md
# Tournament Branch Direction Predictor

This block guesses whether a conditional branch will be taken. It runs two direction predictors side by side. The first is a per-branch (local) predictor: a table of branch-private outcome histories, where each history selects a 2-bit saturating counter. The second is a path (global) predictor: a single shift register holds the most recent outcomes of all branches, and that register selects a 2-bit counter. A third table of 2-bit counters, the chooser, learns which of the two predictors is more reliable in the current context. A multiplexer then passes on the chosen predictor's guess.

Fetch logic presents a branch address on the predict port and reads back the final direction and both component guesses in the same cycle. It keeps the component guesses with the branch. When the branch resolves, the update port receives the branch address, the real outcome and the two saved guesses. Both component predictors are trained on every update. The chooser is trained only when the two saved guesses differed. Updates must arrive in the order the predictions were made, with no other update in between. This ensures that the shared path history and the per-branch history still hold the values they had at predict time.

Top module: `tourney_bp`

## Requirements
- R1: After a synchronous active-low reset, every counter holds 01 (weakly not taken) and every history is zero, so `pred_taken`, `pred_local` and `pred_global` are all 0 for any address.
- R2: Every counter saturates: a taken update raises it by one up to 3, and a not-taken update lowers it by one down to 0. A counter predicts taken when its value is 2 or 3, i.e. when its upper bit is 1.
- R3: The local predictor holds 2^10 histories of 10 bits, selected directly by the value of `pred_pc`/`upd_pc`. The history value directly selects one of 2^10 local counters, whose upper bit is `pred_local`. On update, the outcome is shifted into bit 0 of that branch's history and the older bits move up one place.
- R4: The path history is 12 bits. On every update, the outcome is shifted into bit 0 and the older bits move up one place. The history value directly selects one of 2^12 global counters, whose upper bit is `pred_global`.
- R5: The chooser table has 2^12 counters and is selected by the path history. When the selected chooser counter is 2 or 3, `pred_taken` equals `pred_global`; otherwise it equals `pred_local`.
- R6: On an update where `upd_local` and `upd_global` differ, the chooser counter at the current path history steps up if `upd_global` equals `upd_taken` and steps down otherwise. When the two saved guesses are equal, the chooser is left unchanged.
- R7: `pred_local` and `pred_global` always show the component guesses, whichever component the chooser selects.
- R8: While `upd_valid` is 0, no history and no counter changes, whatever the other update inputs carry.
- R9: On every update, the local counter selected by the branch's history and the global counter selected by the path history are both trained with the outcome, whatever the chooser state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| pred_pc | input | 10 | Branch word address bits used to look up a prediction |
| pred_taken | output | 1 | Final direction guess (1 = taken) |
| pred_local | output | 1 | Local predictor's guess |
| pred_global | output | 1 | Global predictor's guess |
| upd_valid | input | 1 | Update strobe for one resolved branch |
| upd_pc | input | 10 | Word address bits of the resolved branch |
| upd_taken | input | 1 | Real outcome of the resolved branch |
| upd_local | input | 1 | Local guess saved at predict time |
| upd_global | input | 1 | Global guess saved at predict time |

## Verification
The assertions assume that `upd_valid` is a clean single-cycle strobe and that the saved guesses are plain bits, which may differ from what the design predicted. They do not assume in-order use. Stimulus keeps each update on the cycle right after its prediction, so the histories match predict time. A small pool of branch addresses with loop-like, biased and random outcome patterns drives the counters to both saturation limits. Some updates deliberately carry corrupted saved guesses, which exercises every chooser training case. A window of idle cycles with noisy update inputs covers the strobe-low case.

// File: rtl/tp_pkg.sv
// Shared types and counter arithmetic for the tournament predictor.
// Assumes every counter in the block uses the same 2-bit width.
package tp_pkg;
    localparam int CTR_W = 2;
    typedef logic [CTR_W-1:0] ctr_t;
    localparam ctr_t CTR_INIT = 2'b01;
    localparam ctr_t CTR_MAX  = 2'b11;
    localparam ctr_t CTR_MIN  = 2'b00;

    // Saturating step of one counter toward taken (up=1) or not taken.
    function automatic ctr_t ctr_step(input ctr_t c, input logic up);
        if (up)
            return (c == CTR_MAX) ? c : c + 2'd1;
        return (c == CTR_MIN) ? c : c - 2'd1;
    endfunction
endpackage

// File: rtl/tp_ctr_table.sv
// Table of 2-bit saturating counters with one read port for lookup and one
// read-modify-write port for training. Assumes one training write per cycle.
module tp_ctr_table
    import tp_pkg::*;
#(
    parameter int IDX_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    output logic             rd_taken,
    input  logic             upd_en,
    input  logic [IDX_W-1:0] upd_idx,
    input  logic             upd_up
);
    localparam int DEPTH = 1 << IDX_W;

    ctr_t mem [DEPTH];
    ctr_t upd_old;

    // Current value of the entry being trained.
    assign upd_old  = mem[upd_idx];
    // Direction bit of the looked-up entry.
    assign rd_taken = mem[rd_idx][CTR_W-1];

    // Reset every entry to weakly not taken, else train one entry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= CTR_INIT;
        end else if (upd_en) begin
            mem[upd_idx] <= ctr_step(upd_old, upd_up);
        end
    end

    AST_CTR_SAT_HI: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en && upd_up && upd_old == CTR_MAX) |=> (mem[$past(upd_idx)] == CTR_MAX)); // R2
    AST_CTR_SAT_LO: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en && !upd_up && upd_old == CTR_MIN) |=> (mem[$past(upd_idx)] == CTR_MIN)); // R2
    AST_CTR_STEP_UP: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en && upd_up && upd_old != CTR_MAX) |=> (mem[$past(upd_idx)] == $past(upd_old) + 2'd1)); // R2
    AST_CTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!upd_en) |=> (mem[$past(rd_idx)] == $past(mem[rd_idx]))); // R8
endmodule

// File: rtl/tp_hist_table.sv
// Table of per-branch outcome histories. One lookup port for prediction and
// one port that reads a history and shifts the new outcome into bit 0.
// Assumes HIST_W is at least 2.
module tp_hist_table #(
    parameter int IDX_W  = 10,
    parameter int HIST_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [HIST_W-1:0] rd_hist,
    input  logic              upd_en,
    input  logic [IDX_W-1:0]  upd_idx,
    input  logic              upd_bit,
    output logic [HIST_W-1:0] upd_hist
);
    localparam int DEPTH = 1 << IDX_W;

    logic [HIST_W-1:0] mem [DEPTH];

    // Lookup of the predicting branch and of the resolving branch.
    assign rd_hist  = mem[rd_idx];
    assign upd_hist = mem[upd_idx];

    // Clear all histories on reset, else append the outcome.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (upd_en) begin
            mem[upd_idx] <= {upd_hist[HIST_W-2:0], upd_bit};
        end
    end

    AST_LHIST_NEWEST: assert property (@(posedge clk) disable iff (!rst_n)
        upd_en |=> (mem[$past(upd_idx)][0] == $past(upd_bit))); // R3
    AST_LHIST_AGE: assert property (@(posedge clk) disable iff (!rst_n)
        upd_en |=> (mem[$past(upd_idx)][HIST_W-1:1] == $past(upd_hist[HIST_W-2:0]))); // R3
    AST_LHIST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!upd_en) |=> (mem[$past(rd_idx)] == $past(mem[rd_idx]))); // R8
endmodule

// File: rtl/tourney_bp.sv
// Tournament direction predictor: a per-branch history predictor and a
// path history predictor, with a chooser table that selects between them.
// Assumes updates arrive in prediction order with no update in between, so
// both histories still match the values used at predict time.
module tourney_bp
    import tp_pkg::*;
#(
    parameter int PC_W    = 10,
    parameter int LHIST_W = 10,
    parameter int GHIST_W = 12
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PC_W-1:0] pred_pc,
    output logic            pred_taken,
    output logic            pred_local,
    output logic            pred_global,
    input  logic            upd_valid,
    input  logic [PC_W-1:0] upd_pc,
    input  logic            upd_taken,
    input  logic            upd_local,
    input  logic            upd_global
);
    logic [GHIST_W-1:0] ghist;
    logic [LHIST_W-1:0] pred_lhist;
    logic [LHIST_W-1:0] upd_lhist;
    logic               use_global;
    logic               chs_train;
    logic               chs_up;

    // Path history: shift each resolved outcome into bit 0.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ghist <= '0;
        else if (upd_valid)
            ghist <= {ghist[GHIST_W-2:0], upd_taken};
    end

    // Chooser learns only when the saved guesses disagree.
    assign chs_train = upd_valid && (upd_local != upd_global);
    assign chs_up    = (upd_global == upd_taken);

    tp_hist_table #(.IDX_W(PC_W), .HIST_W(LHIST_W)) u_lhist (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_idx   (pred_pc),
        .rd_hist  (pred_lhist),
        .upd_en   (upd_valid),
        .upd_idx  (upd_pc),
        .upd_bit  (upd_taken),
        .upd_hist (upd_lhist)
    );

    tp_ctr_table #(.IDX_W(LHIST_W)) u_lctr (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_idx   (pred_lhist),
        .rd_taken (pred_local),
        .upd_en   (upd_valid),
        .upd_idx  (upd_lhist),
        .upd_up   (upd_taken)
    );

    tp_ctr_table #(.IDX_W(GHIST_W)) u_gctr (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_idx   (ghist),
        .rd_taken (pred_global),
        .upd_en   (upd_valid),
        .upd_idx  (ghist),
        .upd_up   (upd_taken)
    );

    tp_ctr_table #(.IDX_W(GHIST_W)) u_chs (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_idx   (ghist),
        .rd_taken (use_global),
        .upd_en   (chs_train),
        .upd_idx  (ghist),
        .upd_up   (chs_up)
    );

    // Final guess comes from the component the chooser favours.
    assign pred_taken = use_global ? pred_global : pred_local;

    AST_GHIST_NEWEST: assert property (@(posedge clk) disable iff (!rst_n)
        upd_valid |=> (ghist[0] == $past(upd_taken))); // R4
    AST_GHIST_AGE: assert property (@(posedge clk) disable iff (!rst_n)
        upd_valid |=> (ghist[GHIST_W-1:1] == $past(ghist[GHIST_W-2:0]))); // R4
    AST_GHIST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!upd_valid) |=> $stable(ghist)); // R8
    AST_AGREE_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (pred_local == pred_global) |-> (pred_taken == pred_local)); // R5
endmodule

// File: tb/tourney_bp_tb.sv
module tourney_bp_tb;
    localparam int PC_W    = 10;
    localparam int LHIST_W = 10;
    localparam int GHIST_W = 12;

    logic clk = 1'b0;
    logic rst_n;
    logic [PC_W-1:0] pred_pc;
    logic pred_taken, pred_local, pred_global;
    logic upd_valid, upd_taken, upd_local, upd_global;
    logic [PC_W-1:0] upd_pc;

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    // Reference state built from the requirements.
    logic [LHIST_W-1:0] m_lhist [1 << PC_W];
    logic [1:0]         m_lctr  [1 << LHIST_W];
    logic [1:0]         m_gctr  [1 << GHIST_W];
    logic [1:0]         m_chs   [1 << GHIST_W];
    logic [GHIST_W-1:0] m_ghist;

    always #5 clk = ~clk;

    tourney_bp #(.PC_W(PC_W), .LHIST_W(LHIST_W), .GHIST_W(GHIST_W)) u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .pred_pc     (pred_pc),
        .pred_taken  (pred_taken),
        .pred_local  (pred_local),
        .pred_global (pred_global),
        .upd_valid   (upd_valid),
        .upd_pc      (upd_pc),
        .upd_taken   (upd_taken),
        .upd_local   (upd_local),
        .upd_global  (upd_global)
    );

    function automatic logic [1:0] sat(input logic [1:0] c, input logic up);
        if (up) return (c == 2'd3) ? 2'd3 : c + 2'd1;
        return (c == 2'd0) ? 2'd0 : c - 2'd1;
    endfunction

    task automatic model_reset();
        for (int i = 0; i < (1 << PC_W); i++) m_lhist[i] = '0;
        for (int i = 0; i < (1 << LHIST_W); i++) m_lctr[i] = 2'd1;
        for (int i = 0; i < (1 << GHIST_W); i++) begin
            m_gctr[i] = 2'd1;
            m_chs[i]  = 2'd1;
        end
        m_ghist = '0;
    endtask

    task automatic model_pred(input logic [PC_W-1:0] pc, output logic el,
                              output logic eg, output logic et);
        el = (m_lctr[m_lhist[pc]] >= 2'd2);
        eg = (m_gctr[m_ghist] >= 2'd2);
        et = (m_chs[m_ghist] >= 2'd2) ? eg : el;
    endtask

    task automatic model_upd(input logic [PC_W-1:0] pc, input logic t,
                             input logic sl, input logic sg);
        logic [LHIST_W-1:0] h;
        h = m_lhist[pc];
        m_lctr[h] = sat(m_lctr[h], t);
        m_gctr[m_ghist] = sat(m_gctr[m_ghist], t);
        if (sl != sg) m_chs[m_ghist] = sat(m_chs[m_ghist], sg == t);
        m_lhist[pc] = {h[LHIST_W-2:0], t};
        m_ghist = {m_ghist[GHIST_W-2:0], t};
    endtask

    task automatic check(input logic act, input logic exp, input string req);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
        end
    endtask

    // Compare all three outputs for one address against the model.
    task automatic compare(input logic [PC_W-1:0] pc, input string tag);
        logic el, eg, et;
        model_pred(pc, el, eg, et);
        check(pred_local,  el, {tag, " R3 R9 local"});
        check(pred_global, eg, {tag, " R4 R7 global"});
        check(pred_taken,  et, {tag, " R5 R6 final"});
    endtask

    // One predict then update; corrupt replaces the saved guesses randomly.
    task automatic step(input logic [PC_W-1:0] pc, input logic t, input logic corrupt);
        logic sl, sg;
        @(negedge clk);
        upd_valid = 1'b0;
        pred_pc = pc;
        #1;
        compare(pc, "step");
        sl = corrupt ? 1'($urandom) : pred_local;
        sg = corrupt ? 1'($urandom) : pred_global;
        upd_pc = pc;
        upd_taken = t;
        upd_local = sl;
        upd_global = sg;
        upd_valid = 1'b1;
        @(posedge clk);
        model_upd(pc, t, sl, sg);
    endtask

    initial begin
        #2000000;
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        logic [PC_W-1:0] pool [16];
        int ctr [16];
        void'($urandom(32'd20240611));
        rst_n = 1'b0;
        pred_pc = '0;
        upd_valid = 1'b0;
        upd_pc = '0;
        upd_taken = 1'b0;
        upd_local = 1'b0;
        upd_global = 1'b0;
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: all predictions not taken right after reset.
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            pred_pc = PC_W'(i * 97);
            #1;
            check(pred_local,  1'b0, "R1 local after reset");
            check(pred_global, 1'b0, "R1 global after reset");
            check(pred_taken,  1'b0, "R1 final after reset");
        end

        // R2: a long taken run saturates both components at taken.
        for (int i = 0; i < 20; i++) step(10'd5, 1'b1, 1'b0);
        @(negedge clk);
        upd_valid = 1'b0;
        pred_pc = 10'd5;
        #1;
        check(pred_local,  1'b1, "R2 local saturated taken");
        check(pred_global, 1'b1, "R2 global saturated taken");
        // R2: a long not-taken run drives both back to not taken.
        for (int i = 0; i < 20; i++) step(10'd5, 1'b0, 1'b0);
        @(negedge clk);
        upd_valid = 1'b0;
        #1;
        check(pred_local,  1'b0, "R2 local saturated not taken");
        check(pred_global, 1'b0, "R2 global saturated not taken");

        // Random phase over a small address pool with mixed behaviours.
        for (int i = 0; i < 16; i++) begin
            pool[i] = PC_W'($urandom);
            ctr[i] = 0;
        end
        for (int n = 0; n < 4000; n++) begin
            int k;
            logic t;
            k = int'($urandom % 16);
            ctr[k]++;
            case (k % 4)
                0: t = ((ctr[k] % 5) != 0);
                1: t = ((ctr[k] % 2) == 0);
                2: t = (($urandom % 8) != 0);
                default: t = 1'($urandom);
            endcase
            step(pool[k], t, ($urandom % 8) == 0);
        end

        // R8: strobe low with noisy update inputs changes nothing.
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            upd_valid = 1'b0;
            upd_pc = PC_W'($urandom);
            upd_taken = 1'($urandom);
            upd_local = 1'($urandom);
            upd_global = 1'($urandom);
        end
        for (int i = 0; i < 16; i++) begin
            @(negedge clk);
            pred_pc = pool[i];
            #1;
            compare(pool[i], "R8 idle");
        end

        finished = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule